// File: doc/BRIEF.md
# Index Sensor Sampling Control Register Bank

This block is the register file and sequencer in front of a single-channel sensor that yields an 8-bit index value. A host reaches it through a plain register port: address, write data, a write strobe, a read strobe and a read data return. The block decides when the conversion stage is asked for a new sample. A request comes from a one-shot command bit that clears itself, or from a periodic mode that fires on each pulse of a timebase input. Both sources are blocked while the power-down bit is set.

Results arrive from the conversion stage as a valid pulse with an 8-bit value. They are latched into an output register, and a data-available flag is raised. Reading the output register clears that flag. A block-update option protects the held value: a result that has not been read is not overwritten. The serial transport, the converter, memory reload and interrupt generation sit outside this block.

Top module: `idx_sample_ctl`

## Requirements
- R1: Address 0x0F always reads 0xCA. Writes to it change nothing.
- R2: Address 0x20 is the configuration register and resets to 0x80. Only bit 7 (power-down, 1 = off), bit 1 (block update) and bit 0 (periodic, 1 = on) are writable. All other bits read 0.
- R3: Address 0x21 is the mode register and resets to 0x00. Bits 4 and 3 are stored as written. Bits 6, 5, 2 and 1 always read 0.
- R4: A write to 0x21 with bit 0 set, made while 0x20 bit 7 is 0, drives `convReq` high for exactly the one cycle after the write edge. Bit 0 of 0x21 always reads 0.
- R5: A one-shot write made while 0x20 bit 7 is 1 produces no `convReq`.
- R6: With 0x20 bit 0 set and bit 7 clear, each `tick` pulse drives `convReq` high for the next cycle. `tick` has no effect when bit 0 is 0 or bit 7 is 1.
- R7: Writing 1 to 0x21 bit 7 makes that bit read 1 for one cycle. It then returns to 0 unless it is written again.
- R8: With block update off (0x20 bit 1 = 0), a `sampleValid` pulse loads `sampleData` into 0x28 and sets 0x27 bit 0. Both are visible from the next cycle.
- R9: A read strobe at 0x28 clears 0x27 bit 0 from the next cycle. If an accepted sample arrives in the same cycle, the sample wins and the flag stays set.
- R10: With block update on, a sample that arrives while 0x27 bit 0 is 1 is discarded. 0x28 and the flag keep their values. Once the value has been read, the next sample is accepted.
- R11: Addresses 0x27 and 0x28 ignore writes. 0x27 bits 7..1 read 0. Every unmapped address reads 0x00.
- R12: A one-shot write and an enabled tick in the same cycle produce a single one-cycle `convReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 8 | Register address |
| regWrData | input | 8 | Write data |
| regWr | input | 1 | Write strobe, one cycle per write |
| regRd | input | 1 | Read strobe. Needed only for the read side effect at 0x28 |
| regRdData | output | 8 | Read data for `regAddr`, combinational |
| tick | input | 1 | Timebase pulse for periodic mode |
| sampleValid | input | 1 | Result from the conversion stage is valid |
| sampleData | input | 8 | Result value |
| convReq | output | 1 | One-cycle conversion request |

## Verification
Read data is combinational, so it is compared in the same cycle the address is driven. `convReq` and every register update belong to the first clock edge after a stimulus. The bench therefore drives each stimulus just after a falling edge and samples `regRdData` one step later. It samples `convReq` one step after the following rising edge. The next step's check confirms that the request has dropped and that the update is visible. A bench model holds the pre-edge state, so the gating and the block-update decision both use the values that stood before the edge, as the registers do.

// File: rtl/idx_sample_pkg.sv
package idx_sample_pkg;
  typedef struct packed {
    logic wrCfg;   // write hits configuration register
    logic wrMode;  // write hits mode register
    logic rdOut;   // read strobe hits output data register
    logic fire;    // a conversion request is issued this cycle
  } seqStrobe_t;
endpackage

// File: rtl/idx_sample_seq.sv
module idx_sample_seq
  import idx_sample_pkg::*;
#(
  parameter int AW = 8,
  parameter logic [AW-1:0] ADDR_CFG = 8'h20,
  parameter logic [AW-1:0] ADDR_MODE = 8'h21,
  parameter logic [AW-1:0] ADDR_OUT = 8'h28
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] regAddr,
  input  logic          regWr,
  input  logic          regRd,
  input  logic          oneShotBit,
  input  logic          tick,
  input  logic          powerDown,
  input  logic          periodicOn,
  output seqStrobe_t    strb,
  output logic          convReq
);
  logic hitCfg, hitMode, hitOut;
  logic oneShotHit, periodicHit;

  assign hitCfg  = (regAddr == ADDR_CFG);
  assign hitMode = (regAddr == ADDR_MODE);
  assign hitOut  = (regAddr == ADDR_OUT);

  assign oneShotHit  = regWr && hitMode && oneShotBit;
  assign periodicHit = tick && periodicOn;

  always_comb begin
    strb.wrCfg  = regWr && hitCfg;
    strb.wrMode = regWr && hitMode;
    strb.rdOut  = regRd && hitOut;
    strb.fire   = !powerDown && (oneShotHit || periodicHit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) convReq <= 1'b0;
    else       convReq <= strb.fire;
  end

  // R5: a request only follows a cycle in which the block was powered up
  assert_req_powered_R5: assert property (@(posedge clk) disable iff (!rstN)
    convReq |-> !$past(powerDown));

  // R6: an idle cycle with no command and no tick brings no request
  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!regWr && !tick) |=> !convReq);
endmodule

// File: rtl/idx_sample_dp.sv
module idx_sample_dp
  import idx_sample_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] ADDR_ID = 8'h0F,
  parameter logic [AW-1:0] ADDR_CFG = 8'h20,
  parameter logic [AW-1:0] ADDR_MODE = 8'h21,
  parameter logic [AW-1:0] ADDR_STAT = 8'h27,
  parameter logic [AW-1:0] ADDR_OUT = 8'h28,
  parameter logic [DW-1:0] ID_VALUE = 8'hCA
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqStrobe_t    strb,
  input  logic [AW-1:0] regAddr,
  input  logic [DW-1:0] regWrData,
  output logic [DW-1:0] regRdData,
  input  logic          sampleValid,
  input  logic [DW-1:0] sampleData,
  output logic          powerDown,
  output logic          periodicOn
);
  localparam int PD_BIT = 7;
  localparam int BDU_BIT = 1;
  localparam int RATE_BIT = 0;
  localparam int BOOT_BIT = 7;
  localparam logic [DW-1:0] CFG_KEEP = DW'(8'h83);
  localparam logic [DW-1:0] CFG_INIT = DW'(8'h80);
  localparam logic [DW-1:0] MODE_KEEP = DW'(8'h18);

  logic [DW-1:0] cfgQ, modeQ, dataQ;
  logic          bootQ, availQ;
  logic          holdBdu, acceptSample;

  assign powerDown  = cfgQ[PD_BIT];
  assign periodicOn = cfgQ[RATE_BIT];
  assign holdBdu    = cfgQ[BDU_BIT];
  assign acceptSample = sampleValid && !(holdBdu && availQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ  <= CFG_INIT;
      modeQ <= '0;
      bootQ <= 1'b0;
    end else begin
      if (strb.wrCfg)  cfgQ  <= regWrData & CFG_KEEP;
      if (strb.wrMode) modeQ <= regWrData & MODE_KEEP;
      bootQ <= strb.wrMode && regWrData[BOOT_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ  <= '0;
      availQ <= 1'b0;
    end else if (acceptSample) begin
      dataQ  <= sampleData;
      availQ <= 1'b1;
    end else if (strb.rdOut) begin
      availQ <= 1'b0;
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_ID)   regRdData = ID_VALUE;
    if (regAddr == ADDR_CFG)  regRdData = cfgQ;
    if (regAddr == ADDR_MODE) begin
      regRdData = modeQ;
      regRdData[BOOT_BIT] = bootQ;
    end
    if (regAddr == ADDR_STAT) regRdData[0] = availQ;
    if (regAddr == ADDR_OUT)  regRdData = dataQ;
  end

  // R8: the flag rises only after a sample pulse
  assert_avail_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(availQ) |-> $past(sampleValid));
  // R9: a read with no sample clears the flag
  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdOut && !sampleValid) |=> !availQ);
  // R10: an unread value is kept while block update is on
  assert_bdu_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (holdBdu && availQ) |=> $stable(dataQ));
  // R7: the reboot bit drops by itself
  assert_boot_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (bootQ && !strb.wrMode) |=> !bootQ);
  // R2: reserved configuration bits never set
  assert_cfg_reserved_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ & ~CFG_KEEP) == '0);
endmodule

// File: rtl/idx_sample_ctl.sv
module idx_sample_ctl
  import idx_sample_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] regAddr,
  input  logic [DW-1:0] regWrData,
  input  logic          regWr,
  input  logic          regRd,
  output logic [DW-1:0] regRdData,
  input  logic          tick,
  input  logic          sampleValid,
  input  logic [DW-1:0] sampleData,
  output logic          convReq
);
  seqStrobe_t strb;
  logic powerDown, periodicOn;

  idx_sample_seq #(.AW(AW)) uSeq (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .oneShotBit(regWrData[0]), .tick(tick), .powerDown(powerDown),
    .periodicOn(periodicOn), .strb(strb), .convReq(convReq)
  );

  idx_sample_dp #(.AW(AW), .DW(DW)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .sampleValid(sampleValid),
    .sampleData(sampleData), .powerDown(powerDown), .periodicOn(periodicOn)
  );
endmodule

// File: tb/idx_sample_ctl_test.sv
`timescale 1ns/1ps
module idx_sample_ctl_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] regAddr = '0, regWrData = '0, sampleData = '0;
  logic regWr = 1'b0, regRd = 1'b0, tick = 1'b0, sampleValid = 1'b0;
  logic [7:0] regRdData;
  logic convReq;
  int checks = 0, fails = 0;

  // bench model of the register state
  logic [7:0] mCfg = 8'h80, mMode = 8'h00, mData = 8'h00;
  logic mBoot = 1'b0, mAvail = 1'b0;

  always #5 clk = ~clk;

  idx_sample_ctl uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
    .regWr(regWr), .regRd(regRd), .regRdData(regRdData), .tick(tick),
    .sampleValid(sampleValid), .sampleData(sampleData), .convReq(convReq)
  );

  function automatic logic [7:0] expRead(input logic [7:0] a);
    case (a)
      8'h0F: return 8'hCA;
      8'h20: return mCfg;
      8'h21: return {mBoot, 7'b0} | mMode;
      8'h27: return {7'b0, mAvail};
      8'h28: return mData;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic [7:0] a, input logic [7:0] wd,
                      input logic w, input logic r, input logic tk,
                      input logic sv, input logic [7:0] sd);
    logic expReq;
    logic accept;
    regAddr = a; regWrData = wd; regWr = w; regRd = r; tick = tk;
    sampleValid = sv; sampleData = sd;
    #1;
    check(tag, "read data", regRdData, expRead(a));
    expReq = !mCfg[7] && ((w && a == 8'h21 && wd[0]) || (tk && mCfg[0]));
    accept = sv && !(mCfg[1] && mAvail);
    @(posedge clk);
    #1;
    check(tag, "convReq", {7'b0, convReq}, {7'b0, expReq});
    mBoot = w && a == 8'h21 && wd[7];
    if (w && a == 8'h20) mCfg = wd & 8'h83;
    if (w && a == 8'h21) mMode = wd & 8'h18;
    if (accept) begin mData = sd; mAvail = 1'b1; end
    else if (r && a == 8'h28) mAvail = 1'b0;
    @(negedge clk);
    regWr = 0; regRd = 0; tick = 0; sampleValid = 0;
  endtask

  task automatic idle(input string tag, input logic [7:0] a);
    step(tag, a, 8'h00, 0, 0, 0, 0, 8'h00);
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state, hard-coded values
    regAddr = 8'h0F; #1 check("R1", "identity", regRdData, 8'hCA);
    regAddr = 8'h20; #1 check("R2", "cfg reset", regRdData, 8'h80);
    regAddr = 8'h21; #1 check("R3", "mode reset", regRdData, 8'h00);
    regAddr = 8'h27; #1 check("R11", "status reset", regRdData, 8'h00);
    regAddr = 8'h28; #1 check("R8", "data reset", regRdData, 8'h00);
    regAddr = 8'h55; #1 check("R11", "unmapped", regRdData, 8'h00);
    @(negedge clk);

    step("R5", 8'h21, 8'h01, 1, 0, 0, 0, 0);     // one-shot while powered down
    idle("R5", 8'h21);
    step("R2", 8'h20, 8'hFF, 1, 0, 0, 0, 0);
    idle("R2", 8'h20);                             // reads 0x83
    step("R6", 8'h20, 8'h00, 1, 0, 0, 0, 0);
    step("R6", 8'h20, 8'h00, 0, 0, 1, 0, 0);       // tick with periodic off
    step("R4", 8'h21, 8'h01, 1, 0, 0, 0, 0);       // one-shot fires
    idle("R4", 8'h21);                             // request dropped, bit 0 reads 0
    step("R6", 8'h20, 8'h01, 1, 0, 0, 0, 0);
    step("R6", 8'h20, 8'h00, 0, 0, 1, 0, 0);       // tick fires
    idle("R6", 8'h20);
    step("R12", 8'h21, 8'h01, 1, 0, 1, 0, 0);      // one-shot and tick together
    idle("R12", 8'h21);
    step("R6", 8'h20, 8'h81, 1, 0, 0, 0, 0);
    step("R6", 8'h20, 8'h00, 0, 0, 1, 0, 0);       // powered down tick
    step("R5", 8'h21, 8'h01, 1, 0, 0, 0, 0);
    step("R7", 8'h21, 8'h98, 1, 0, 0, 0, 0);
    idle("R7", 8'h21);                             // reads 0x98
    idle("R7", 8'h21);                             // reads 0x18
    step("R3", 8'h21, 8'hFF, 1, 0, 0, 0, 0);
    idle("R3", 8'h21);
    idle("R3", 8'h21);
    step("R1", 8'h0F, 8'h00, 1, 0, 0, 0, 0);
    idle("R1", 8'h0F);
    step("R2", 8'h20, 8'h00, 1, 0, 0, 0, 0);
    step("R8", 8'h28, 8'h00, 0, 0, 0, 1, 8'h3C);
    idle("R8", 8'h28);
    idle("R8", 8'h27);
    step("R11", 8'h27, 8'hFF, 1, 0, 0, 0, 0);
    step("R11", 8'h28, 8'h55, 1, 0, 0, 0, 0);
    idle("R11", 8'h27);
    idle("R11", 8'h28);
    step("R9", 8'h28, 8'h00, 0, 1, 0, 0, 0);      // read clears
    idle("R9", 8'h27);
    step("R9", 8'h28, 8'h00, 0, 0, 0, 1, 8'h11);
    step("R9", 8'h28, 8'h00, 0, 1, 0, 1, 8'h22);  // read and sample together
    idle("R9", 8'h27);
    idle("R9", 8'h28);
    step("R10", 8'h20, 8'h02, 1, 0, 0, 0, 0);
    step("R10", 8'h28, 8'h00, 0, 0, 0, 1, 8'h77); // discarded
    idle("R10", 8'h28);
    idle("R10", 8'h27);
    step("R10", 8'h28, 8'h00, 0, 1, 0, 1, 8'h99); // read with sample, still held
    idle("R10", 8'h28);
    step("R10", 8'h28, 8'h00, 0, 0, 0, 1, 8'h66); // accepted after read
    idle("R10", 8'h28);
    idle("R10", 8'h27);

    // constrained random phase
    for (int i = 0; i < 600; i++) begin
      logic [7:0] a, wd;
      logic [2:0] pick;
      pick = 3'($urandom_range(0, 5));
      case (pick)
        3'd0: a = 8'h0F;
        3'd1: a = 8'h20;
        3'd2: a = 8'h21;
        3'd3: a = 8'h27;
        3'd4: a = 8'h28;
        default: a = 8'($urandom);
      endcase
      wd = 8'($urandom);
      if (a == 8'h20 && ($urandom_range(0, 3) != 0)) wd[7] = 1'b0;
      step("R6", a, wd, ($urandom_range(0, 3) == 0), ($urandom_range(0, 2) == 0),
           ($urandom_range(0, 2) == 0), ($urandom_range(0, 2) == 0), 8'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule